// File: doc/BRIEF.md
# Privilege-Gated Counter Shadow Unit

This block keeps the machine-level event counters of a processor core: a 64-bit clock-cycle counter, a 64-bit retired-instruction counter and a parameterised set of programmable event counters. It serves CSR read requests for their read-only shadow copies, and for a shadow of the 64-bit real-time value that an external timer supplies. A 32-bit machine-level enable register gates these reads one bit at a time. Machine code can always read every shadow. Supervisor and user code can read a shadow only while its enable bit is set. Any other access is refused through an illegal-instruction flag, which the core's trap logic picks up.

The CSR port is combinational. A request presents an address, a write flag, write data and the current privilege level. The read data and the illegal flag are valid in the same cycle, and an enable-register write takes effect at the next clock edge. In the 32-bit configuration the upper half of every shadow has its own address. The counters run on their own strobes whether or not anyone may read them.

Top module: `ctrgate_top`

## Requirements
- R1: The enable register sits at address 0x306. A machine-mode (privilege 2'b11) write stores the write data ANDed with the writable mask, and the store takes effect at the next clock. A machine-mode read returns the stored value. The register is zero after reset.
- R2: Privilege 2'b00 or 2'b01 counts as lower privilege. A lower-privilege read of shadow index n (address 0xC00+n, or 0xC80+n for the upper half) while enable bit n is clear raises csrIllegal, and csrRdata is then zero.
- R3: A lower-privilege shadow read with its enable bit set returns the counter value. A machine-mode shadow read always returns the counter value, whatever the enable bits hold.
- R4: Index 0 shadows the cycle counter. It is zero after reset and increases by one on every clock.
- R5: Index 2 shadows the retired-instruction counter, which increments when retireStrobe is high. Index 3+k shadows event counter k, which increments when eventStrobe[k] is high.
- R6: Index 1 shadows rtcValue. The low address returns bits 31:0.
- R7: With XLEN=32, addresses 0xC80+n return bits 63:32 of shadow n. These reads are gated by the same enable bit n.
- R8: A write to any shadow address raises csrIllegal at every privilege level and leaves all counters unchanged.
- R9: A lower-privilege access to the enable register raises csrIllegal. Accesses to the enable register never change any counter.
- R10: When HAS_UMODE=0 the enable register does not exist. Every access to 0x306 raises csrIllegal, and every lower-privilege shadow read traps.
- R11: Enable bits for unimplemented counters (index 3+NUM_EVENT and above) and bits cleared in EN_WRITABLE read as zero and cannot be set. Lower-privilege reads of those shadows therefore always trap. An unimplemented shadow reads as zero from machine mode.
- R12: Any address other than the enable register and the shadow ranges raises csrIllegal when csrValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrValid | input | 1 | CSR access request this cycle |
| csrWrite | input | 1 | Request is a write |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | XLEN | Write data |
| csrPriv | input | 2 | Current privilege (11 machine, 01 supervisor, 00 user) |
| retireStrobe | input | 1 | One instruction retired |
| eventStrobe | input | NUM_EVENT | One strobe per event counter |
| rtcValue | input | 64 | Real-time value from the external timer |
| csrRdata | output | XLEN | Read data, zero on illegal or non-read access |
| csrIllegal | output | 1 | Illegal-instruction indication |

## Verification
Two things can fall in the same cycle. A counter can advance on the edge that ends a cycle in which its shadow is read, and an enable-register write can land just before a lower-privilege read of the shadow it unlocks. The bench mixes random retire and event strobes, random privilege levels and random enable-register writes with shadow reads. It then expects each read to return the value held before that edge's increment. The enable bit in force is the one written in an earlier cycle, never the one being written in the same cycle.

// File: rtl/ctrgate_pkg.sv
package ctrgate_pkg;

  localparam logic [11:0] ADDR_ENABLE = 12'h306;
  localparam logic [6:0]  PAGE_LOW    = 7'h60;  // 0xC00..0xC1F
  localparam logic [6:0]  PAGE_HIGH   = 7'h64;  // 0xC80..0xC9F
  localparam logic [1:0]  PRIV_MACH   = 2'b11;

  typedef struct packed {
    logic       enWrite;
    logic       enRead;
    logic       shRead;
    logic       shHigh;
    logic [4:0] idx;
    logic       illegal;
  } ctlStrobes_t;

endpackage

// File: rtl/ctrgate_ctrl.sv
module ctrgate_ctrl
  import ctrgate_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_UMODE = 1'b1
) (
  input  logic        csrValid,
  input  logic        csrWrite,
  input  logic [11:0] csrAddr,
  input  logic [1:0]  csrPriv,
  input  logic [31:0] enableReg,
  output ctlStrobes_t strb
);

  localparam bit SPLIT_HALVES = (XLEN == 32);

  logic isMach;
  logic enHit;
  logic loHit;
  logic hiHit;
  logic gateOpen;
  logic bad;

  always_comb begin
    isMach   = (csrPriv == PRIV_MACH);
    enHit    = (csrAddr == ADDR_ENABLE);
    loHit    = (csrAddr[11:5] == PAGE_LOW);
    hiHit    = SPLIT_HALVES && (csrAddr[11:5] == PAGE_HIGH);
    gateOpen = isMach || enableReg[csrAddr[4:0]];

    if (enHit) begin
      bad = !HAS_UMODE || !isMach;
    end else if (loHit || hiHit) begin
      bad = csrWrite || !gateOpen;
    end else begin
      bad = 1'b1;
    end

    strb.illegal = csrValid && bad;
    strb.enWrite = csrValid && enHit && csrWrite && !bad;
    strb.enRead  = csrValid && enHit && !csrWrite && !bad;
    strb.shRead  = csrValid && (loHit || hiHit) && !bad;
    strb.shHigh  = hiHit;
    strb.idx     = csrAddr[4:0];
  end

endmodule

// File: rtl/ctrgate_datapath.sv
module ctrgate_datapath
  import ctrgate_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          NUM_EVENT = 4,
  parameter bit          HAS_UMODE = 1'b1,
  parameter logic [31:0] EN_MASK   = 32'h0000_007F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [XLEN-1:0]      csrWdata,
  input  logic                 retireStrobe,
  input  logic [NUM_EVENT-1:0] eventStrobe,
  input  logic [63:0]          rtcValue,
  output logic [XLEN-1:0]      csrRdata,
  output logic                 csrIllegal,
  output logic [63:0]          cycleCnt,
  output logic [63:0]          instretCnt,
  output logic [31:0]          enableReg
);

  localparam int SLOTS = 32;

  logic [63:0] evCnt    [NUM_EVENT];
  logic [63:0] cntView  [SLOTS];
  logic [63:0] selCount;
  logic [XLEN-1:0] shadowWord;

  // free-running counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt   <= '0;
      instretCnt <= '0;
    end else begin
      cycleCnt <= cycleCnt + 64'd1;
      if (retireStrobe) instretCnt <= instretCnt + 64'd1;
    end
  end

  for (genvar k = 0; k < NUM_EVENT; k++) begin : g_event
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               evCnt[k] <= '0;
      else if (eventStrobe[k]) evCnt[k] <= evCnt[k] + 64'd1;
    end
  end

  // enable mask register, absent without a user mode
  if (HAS_UMODE) begin : g_enable
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             enableReg <= '0;
      else if (strb.enWrite) enableReg <= csrWdata[31:0] & EN_MASK;
    end
  end else begin : g_no_enable
    assign enableReg = '0;
  end

  // shadow index map
  for (genvar i = 0; i < SLOTS; i++) begin : g_view
    if (i == 0) begin : g_cyc
      assign cntView[i] = cycleCnt;
    end else if (i == 1) begin : g_rtc
      assign cntView[i] = rtcValue;
    end else if (i == 2) begin : g_ir
      assign cntView[i] = instretCnt;
    end else if (i - 3 < NUM_EVENT) begin : g_ev
      assign cntView[i] = evCnt[i-3];
    end else begin : g_none
      assign cntView[i] = '0;
    end
  end

  assign selCount = cntView[strb.idx];

  if (XLEN == 32) begin : g_split
    assign shadowWord = strb.shHigh ? selCount[63:32] : selCount[31:0];
  end else begin : g_full
    assign shadowWord = selCount[XLEN-1:0];
  end

  always_comb begin
    csrRdata = '0;
    if (strb.enRead)      csrRdata = XLEN'(enableReg);
    else if (strb.shRead) csrRdata = shadowWord;
  end

  assign csrIllegal = strb.illegal;

endmodule

// File: rtl/ctrgate_top.sv
module ctrgate_top
  import ctrgate_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          NUM_EVENT   = 4,
  parameter bit          HAS_UMODE   = 1'b1,
  parameter logic [31:0] EN_WRITABLE = 32'hFFFF_FFFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csrValid,
  input  logic                 csrWrite,
  input  logic [11:0]          csrAddr,
  input  logic [XLEN-1:0]      csrWdata,
  input  logic [1:0]           csrPriv,
  input  logic                 retireStrobe,
  input  logic [NUM_EVENT-1:0] eventStrobe,
  input  logic [63:0]          rtcValue,
  output logic [XLEN-1:0]      csrRdata,
  output logic                 csrIllegal
);

  localparam logic [31:0] IMPL_MASK = 32'((64'd1 << (NUM_EVENT + 3)) - 64'd1);
  localparam logic [31:0] EN_MASK   = HAS_UMODE ? (EN_WRITABLE & IMPL_MASK) : 32'h0;

  ctlStrobes_t strb;
  logic [63:0] cycleCnt;
  logic [63:0] instretCnt;
  logic [31:0] enableReg;

  ctrgate_ctrl #(
    .XLEN(XLEN), .HAS_UMODE(HAS_UMODE)
  ) u_ctrl (
    .csrValid (csrValid),
    .csrWrite (csrWrite),
    .csrAddr  (csrAddr),
    .csrPriv  (csrPriv),
    .enableReg(enableReg),
    .strb     (strb)
  );

  ctrgate_datapath #(
    .XLEN(XLEN), .NUM_EVENT(NUM_EVENT), .HAS_UMODE(HAS_UMODE), .EN_MASK(EN_MASK)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .csrWdata    (csrWdata),
    .retireStrobe(retireStrobe),
    .eventStrobe (eventStrobe),
    .rtcValue    (rtcValue),
    .csrRdata    (csrRdata),
    .csrIllegal  (csrIllegal),
    .cycleCnt    (cycleCnt),
    .instretCnt  (instretCnt),
    .enableReg   (enableReg)
  );

endmodule

// File: rtl/ctrgate_chk.sv
module ctrgate_chk #(
  parameter int          XLEN      = 32,
  parameter bit          HAS_UMODE = 1'b1,
  parameter logic [31:0] EN_MASK   = 32'h0000_007F
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrValid,
  input logic            csrWrite,
  input logic [11:0]     csrAddr,
  input logic [XLEN-1:0] csrWdata,
  input logic [1:0]      csrPriv,
  input logic            retireStrobe,
  input logic [XLEN-1:0] csrRdata,
  input logic            csrIllegal,
  input logic [63:0]     cycleCnt,
  input logic [63:0]     instretCnt,
  input logic [31:0]     enableReg
);

  logic shadowAddr;
  assign shadowAddr = (csrAddr[11:5] == 7'h60) || (csrAddr[11:5] == 7'h64);

  a_r1_enable_store: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_UMODE && csrValid && csrWrite && csrAddr == 12'h306 && csrPriv == 2'b11)
      |=> enableReg == ($past(csrWdata[31:0]) & EN_MASK));

  a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !csrWrite && csrPriv != 2'b11 && shadowAddr && !enableReg[csrAddr[4:0]])
      |-> csrIllegal);

  a_r2_zero_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> csrRdata == '0);

  a_r4_cycle_runs: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cycleCnt == $past(cycleCnt) + 64'd1);

  a_r5_retire_step: assert property (@(posedge clk) disable iff (!rstN)
    retireStrobe |=> instretCnt == $past(instretCnt) + 64'd1);

  a_r5_retire_hold: assert property (@(posedge clk) disable iff (!rstN)
    !retireStrobe |=> $stable(instretCnt));

  a_r8_shadow_write: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrWrite && shadowAddr) |-> csrIllegal);

  a_r10_no_enable_reg: assert property (@(posedge clk) disable iff (!rstN)
    (!HAS_UMODE && csrValid && csrAddr == 12'h306) |-> csrIllegal);

  a_r11_fixed_zero: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (enableReg & ~EN_MASK) == 32'h0);

endmodule

bind ctrgate_top ctrgate_chk #(
  .XLEN(XLEN), .HAS_UMODE(HAS_UMODE), .EN_MASK(EN_MASK)
) u_chk (.*);

// File: tb/sim_ctrgate_top.sv
`timescale 1ns/1ps
module sim_ctrgate_top;

  localparam int NEV = 4;
  localparam logic [31:0] U0_MASK = 32'h0000_005F; // bits 0..6 implemented, bit 5 hard-wired

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrValid = 1'b0, csrWrite = 1'b0, retireStrobe = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic [1:0] csrPriv = 2'b11;
  logic [NEV-1:0] eventStrobe = '0;
  logic [63:0] rtcValue = '0;
  logic [31:0] rd0, rd1;
  logic ill0, ill1;

  always #2.5 clk = ~clk;

  ctrgate_top #(.XLEN(32), .NUM_EVENT(NEV), .HAS_UMODE(1'b1), .EN_WRITABLE(32'hFFFF_FFDF)) u0 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrPriv(csrPriv), .retireStrobe(retireStrobe),
    .eventStrobe(eventStrobe), .rtcValue(rtcValue), .csrRdata(rd0), .csrIllegal(ill0));

  ctrgate_top #(.XLEN(32), .NUM_EVENT(NEV), .HAS_UMODE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrPriv(csrPriv), .retireStrobe(retireStrobe),
    .eventStrobe(eventStrobe), .rtcValue(rtcValue), .csrRdata(rd1), .csrIllegal(ill1));

  // behavioural reference state
  longint unsigned mCyc, mIr;
  longint unsigned mEv [NEV];
  logic [31:0] mEn;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCyc <= 0; mIr <= 0; mEn <= '0;
      for (int k = 0; k < NEV; k++) mEv[k] <= 0;
    end else begin
      mCyc <= mCyc + 1;
      if (retireStrobe) mIr <= mIr + 1;
      for (int k = 0; k < NEV; k++) if (eventStrobe[k]) mEv[k] <= mEv[k] + 1;
      if (csrValid && csrWrite && csrAddr == 12'h306 && csrPriv == 2'b11)
        mEn <= csrWdata & U0_MASK;
    end
  end

  function automatic void refOut(input bit hasU, output logic [31:0] rd, output bit ill,
                                 output string tag);
    longint unsigned val;
    int n;
    bit lower;
    logic [31:0] en;
    rd = '0; ill = 1'b0; tag = "R12";
    en = hasU ? mEn : 32'h0;
    lower = (csrPriv != 2'b11);
    if (!csrValid) begin
      tag = "R4";
      return;
    end
    if (csrAddr == 12'h306) begin
      if (!hasU) begin ill = 1'b1; tag = "R10"; end
      else if (lower) begin ill = 1'b1; tag = "R9"; end
      else begin tag = "R1"; if (!csrWrite) rd = en; end
    end else if (csrAddr >= 12'hC00 && csrAddr <= 12'hC1F ||
                 csrAddr >= 12'hC80 && csrAddr <= 12'hC9F) begin
      n = int'(csrAddr[4:0]);
      case (n)
        0: begin val = mCyc; tag = "R4"; end
        1: begin val = rtcValue; tag = "R6"; end
        2: begin val = mIr; tag = "R5"; end
        default: begin
          if (n - 3 < NEV) begin val = mEv[n-3]; tag = "R5"; end
          else begin val = 0; tag = "R11"; end
        end
      endcase
      if (n == 5) tag = "R11";
      if (csrAddr >= 12'hC80) tag = "R7";
      if (!hasU && lower) tag = "R10";
      if (csrWrite) begin ill = 1'b1; tag = "R8"; end
      else if (lower && !en[n]) begin ill = 1'b1; if (hasU) tag = "R2"; end
      else begin
        rd = (csrAddr >= 12'hC80) ? val[63:32] : val[31:0];
        if (lower && tag == "R4") tag = "R3";
      end
    end else begin
      ill = 1'b1;
    end
  endfunction

  task automatic compareNow();
    logic [31:0] e;
    bit ei;
    string t;
    refOut(1'b1, e, ei, t);
    vectors++;
    if (rd0 !== e || ill0 !== ei) begin
      miscompares++;
      $display("FAIL %s u0 addr=%h priv=%0d: got rd=%h ill=%b exp rd=%h ill=%b",
               t, csrAddr, csrPriv, rd0, ill0, e, ei);
    end
    refOut(1'b0, e, ei, t);
    vectors++;
    if (rd1 !== e || ill1 !== ei) begin
      miscompares++;
      $display("FAIL %s u1 addr=%h priv=%0d: got rd=%h ill=%b exp rd=%h ill=%b",
               t, csrAddr, csrPriv, rd1, ill1, e, ei);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic [1:0] p, input logic ret, input logic [NEV-1:0] ev);
    @(negedge clk);
    csrValid = v; csrWrite = w; csrAddr = a; csrWdata = d; csrPriv = p;
    retireStrobe = ret; eventStrobe = ev;
    rtcValue = {$urandom(), $urandom()};
    #1;
    compareNow();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: enable reads zero after reset; R2: lower read traps
    step(1, 0, 12'h306, 0, 2'b11, 0, '0);
    step(1, 0, 12'hC00, 0, 2'b00, 0, '0);
    // R3/R4: machine read of cycle regardless of enable
    step(1, 0, 12'hC00, 0, 2'b11, 1, 4'b0101);
    // R1/R11: write all ones, read back masked
    step(1, 1, 12'h306, 32'hFFFF_FFFF, 2'b11, 1, 4'b1111);
    step(1, 0, 12'h306, 0, 2'b11, 0, '0);
    // R6/R7: time low/high from user, R4 cycle high half
    step(1, 0, 12'hC01, 0, 2'b00, 0, '0);
    step(1, 0, 12'hC81, 0, 2'b00, 0, '0);
    step(1, 0, 12'hC80, 0, 2'b01, 0, '0);
    // R5: instret read while retiring, event counters
    step(1, 0, 12'hC02, 0, 2'b01, 1, 4'b0010);
    step(1, 0, 12'hC04, 0, 2'b00, 0, 4'b0010);
    step(1, 0, 12'hC84, 0, 2'b00, 0, '0);
    // R11: hard-wired bit 5 and unimplemented index 7 trap below M
    step(1, 0, 12'hC05, 0, 2'b00, 0, '0);
    step(1, 0, 12'hC05, 0, 2'b11, 0, '0);
    step(1, 0, 12'hC07, 0, 2'b01, 0, '0);
    step(1, 0, 12'hC07, 0, 2'b11, 0, '0);
    // R8: shadow writes illegal everywhere
    step(1, 1, 12'hC00, 32'h1234, 2'b00, 0, '0);
    step(1, 1, 12'hC03, 32'h1234, 2'b11, 0, '0);
    // R9: lower access to enable register
    step(1, 0, 12'h306, 0, 2'b01, 0, '0);
    step(1, 1, 12'h306, 0, 2'b00, 0, '0);
    // R12: unknown address
    step(1, 0, 12'h123, 0, 2'b11, 0, '0);
    // R2: close the gate, then the same read traps
    step(1, 1, 12'h306, 32'h0, 2'b11, 0, '0);
    step(1, 0, 12'hC00, 0, 2'b00, 0, '0);
    step(0, 0, 12'hC00, 0, 2'b00, 1, 4'b1000);
    // mixed traffic, R10 checked on u1 throughout
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: a = 12'h306;
        1: a = 12'h100 + 12'($urandom_range(0, 255));
        2, 3: a = 12'hC80 + 12'($urandom_range(0, 31));
        default: a = 12'hC00 + 12'($urandom_range(0, 9));
      endcase
      step(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 5) == 0), a, $urandom(),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), NEV'($urandom()));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule